// File: doc/BRIEF.md
# Mailbox Doorbell Console Endpoint

This block is the local end of a byte-wide console link that runs over two shared 32-bit mailbox words and two doorbell words. A remote host reaches them through a simple register port. The local side sees a character stream in each direction, each with a valid/ready handshake. To send a character, the endpoint places it in the transmit mailbox with the top bit set and rings the outgoing doorbell. The remote host frees the mailbox by writing zero to it.

Incoming doorbell messages are handled in hardware, one per cycle. A keep-alive ping is answered with a ping. A connect request flushes the receive path and raises the link. A data message moves the low byte of the receive mailbox into a 256-entry circular buffer.

Flow control uses only the mailboxes. The remote sender may write the receive mailbox again only after it reads zero. The endpoint holds that mailbox nonzero while the buffer is close to full, and releases it once local reads have made room. A local disconnect request drops the link and tells the remote host through the outgoing doorbell.

Top module: `mbx_console_endpoint`

## Requirements
- R1: After reset every register word reads zero, `link_up` and `remote_irq` are 0, `rx_valid` is 0 and `tx_ready` is 1.
- R2: Register offsets are 0 (receive mailbox), 1 (transmit mailbox), 2 (incoming doorbell), 3 (outgoing doorbell) and 4 (status). An accepted character `c` appears at offset 1 as `0x80000000 | c`, and the code 0x5 is ORed into the outgoing doorbell. `tx_ready` stays low while offset 1 is nonzero.
- R3: A NUL character is sent as 0x80000000, so the mailbox still counts as occupied.
- R4: After the character 0x0A is sent, the endpoint sends 0x0D by itself as soon as the remote host zeroes the transmit mailbox. It rings the doorbell again (0x5) and holds `tx_ready` low until then.
- R5: An incoming doorbell value of 0x1 ORs 0x1 into the outgoing doorbell.
- R6: An incoming 0x2 empties the receive buffer, zeroes the receive mailbox, drops any hold and sets the link bit (status bit 1, `link_up`).
- R7: An incoming 0x5 stores bits [7:0] of the receive mailbox into the buffer and zeroes the mailbox. Bytes leave on `rx_data` in arrival order.
- R8: If a store leaves fewer than 4 free entries, the mailbox is not zeroed and a hold is recorded. The mailbox is zeroed one cycle after local reads bring the fill level down to 252 or less.
- R9: A remote write to offset 2 ORs bits into the incoming doorbell. The endpoint clears that doorbell completely in the cycle after it becomes nonzero. A remote write to offset 3 clears the bits written as 1. Status bit 20 shows that the incoming doorbell is pending, status bit 21 shows that the outgoing doorbell is pending, and `remote_irq` is high while the outgoing doorbell is nonzero.
- R10: A pulse on `disc_req` ORs 0x3 into the outgoing doorbell and clears the link.
- R11: Any other nonzero incoming value, including 0x3, is cleared and has no further effect. Every value other than 0x3 also sets status bit 0, and that bit stays set until reset.
- R12: A data message that arrives while the buffer holds 256 entries is dropped, and the fill level never exceeds 256.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tx_valid | input | 1 | Local character to send is valid |
| tx_data | input | 8 | Local character to send |
| tx_ready | output | 1 | Transmit mailbox free, character accepted this cycle |
| rx_valid | output | 1 | Receive buffer holds a byte |
| rx_data | output | 8 | Oldest received byte |
| rx_ready | input | 1 | Local consumer takes the byte |
| disc_req | input | 1 | Local disconnect request pulse |
| link_up | output | 1 | Link connected |
| reg_we | input | 1 | Remote register write strobe |
| reg_addr | input | 3 | Remote register offset |
| reg_wdata | input | 32 | Remote write data |
| reg_rdata | output | 32 | Remote read data (combinational) |
| remote_irq | output | 1 | Outgoing doorbell pending, interrupt to remote host |

## Verification
The receive path is driven with a short run of data words that carry junk in the upper bits. This separates the byte extraction and ordering from any mailbox width effects. A run of 253 stores followed by repeated doorbells, with the mailbox left held, separates three things: the hold threshold, the drop at a full buffer, and the release after reads. The transmit path sends an ordinary letter, a NUL and a newline, which tell apart the marker bit, the occupied-when-nonzero rule and the automatic carriage return. Ping, connect, disconnect and an unlisted code are each sent from an idle state, so the effect of each can be seen on its own.

// File: rtl/mbx_con_pkg.sv
// Shared constants and types for the mailbox console endpoint.
package mbx_con_pkg;
    localparam int MBX_W = 32;

    localparam logic [MBX_W-1:0] MSG_ALIVE = 32'h1;
    localparam logic [MBX_W-1:0] MSG_CONN  = 32'h2;
    localparam logic [MBX_W-1:0] MSG_DISC  = 32'h3;
    localparam logic [MBX_W-1:0] MSG_DATA  = 32'h5;
    localparam logic [MBX_W-1:0] TX_MARK   = 32'h8000_0000;

    localparam int ST_UNKNOWN  = 0;
    localparam int ST_LINK     = 1;
    localparam int ST_IN_PEND  = 20;
    localparam int ST_OUT_PEND = 21;

    typedef enum logic [2:0] {
        A_RXMBX = 3'd0,
        A_TXMBX = 3'd1,
        A_DBIN  = 3'd2,
        A_DBOUT = 3'd3,
        A_STAT  = 3'd4
    } reg_addr_e;

    typedef enum logic [2:0] {
        EV_NONE,
        EV_ALIVE,
        EV_CONN,
        EV_DISC,
        EV_DATA,
        EV_OTHER
    } db_event_e;
endpackage

// File: rtl/mbx_rx_fifo.sv
// Circular receive buffer with a fill count.
// Assumes DEPTH is a power of two so that the pointers wrap on their own.
// A flush takes priority over push and pop. A push into a full buffer is
// blocked by the caller.
module mbx_rx_fifo #(
    parameter int DEPTH = 256,
    parameter int W     = 8,
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush,
    input  logic          push,
    input  logic [W-1:0]  push_data,
    output logic          out_valid,
    output logic [W-1:0]  out_data,
    input  logic          out_ready,
    output logic [CW-1:0] count
);
    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic          pop;

    // Pop happens on a handshake while data is present.
    always_comb begin
        out_valid = (count != '0);
        out_data  = mem[rd_ptr];
        pop       = out_valid && out_ready;
    end

    // Storage array, written on push.
    always_ff @(posedge clk) begin
        if (push && !flush) mem[wr_ptr] <= push_data;
    end

    // Pointer and count update.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push) wr_ptr <= wr_ptr + 1'b1;
            if (pop)  rd_ptr <= rd_ptr + 1'b1;
            case ({push, pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end
endmodule

// File: rtl/mbx_tx_path.sv
// Owns the transmit mailbox. It accepts a character only while the mailbox
// reads zero, marks it with the top bit, and after a newline inserts a
// carriage return once the remote host has freed the mailbox again.
// A remote write to the mailbox takes priority over local loads.
module mbx_tx_path
    import mbx_con_pkg::*;
#(
    parameter int              CHAR_W  = 8,
    parameter logic [CHAR_W-1:0] NL_CHAR = 8'h0A,
    parameter logic [CHAR_W-1:0] CR_CHAR = 8'h0D
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tx_valid,
    input  logic [CHAR_W-1:0] tx_data,
    output logic              tx_ready,
    input  logic              remote_wr,
    input  logic [MBX_W-1:0]  remote_wdata,
    output logic [MBX_W-1:0]  mbx,
    output logic              ring
);
    logic cr_pend;
    logic accept, cr_load, mbx_free;

    // Handshake and load decisions.
    always_comb begin
        mbx_free = (mbx == '0) && !remote_wr;
        tx_ready = mbx_free && !cr_pend;
        accept   = tx_valid && tx_ready;
        cr_load  = mbx_free && cr_pend;
        ring     = accept || cr_load;
    end

    // Mailbox contents and pending carriage return.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mbx     <= '0;
            cr_pend <= 1'b0;
        end else begin
            if (remote_wr)    mbx <= remote_wdata;
            else if (cr_load) mbx <= TX_MARK | MBX_W'(CR_CHAR);
            else if (accept)  mbx <= TX_MARK | MBX_W'(tx_data);
            if (cr_load)                         cr_pend <= 1'b0;
            else if (accept && tx_data == NL_CHAR) cr_pend <= 1'b1;
        end
    end
endmodule

// File: rtl/mbx_db_handler.sv
// Decodes the incoming doorbell word into a single event and keeps the
// sticky flag for values that carry no known meaning.
// Assumes the doorbell word is cleared by the caller whenever the event
// is not EV_NONE.
module mbx_db_handler
    import mbx_con_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [MBX_W-1:0] db_in,
    output db_event_e        ev,
    output logic             unknown_seen
);
    // Map the doorbell value to an event.
    always_comb begin
        unique case (db_in)
            '0:        ev = EV_NONE;
            MSG_ALIVE: ev = EV_ALIVE;
            MSG_CONN:  ev = EV_CONN;
            MSG_DISC:  ev = EV_DISC;
            MSG_DATA:  ev = EV_DATA;
            default:   ev = EV_OTHER;
        endcase
    end

    // Sticky record of an unlisted doorbell value.
    always_ff @(posedge clk) begin
        if (!rst_n)              unknown_seen <= 1'b0;
        else if (ev == EV_OTHER) unknown_seen <= 1'b1;
    end
endmodule

// File: rtl/mbx_console_endpoint.sv
// Local console endpoint over shared mailbox and doorbell words.
// It holds the receive mailbox and both doorbell words, handles one
// incoming doorbell message per cycle, and stalls the remote sender by
// leaving the receive mailbox nonzero while the buffer is nearly full.
// Assumes the remote host writes the receive mailbox only while it reads
// zero, and rings the data doorbell after that write.
module mbx_console_endpoint
    import mbx_con_pkg::*;
#(
    parameter int CHAR_W    = 8,
    parameter int RX_DEPTH  = 256,
    parameter int HOLD_FREE = 4,
    parameter int ADDR_W    = 3,
    localparam int CW       = $clog2(RX_DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tx_valid,
    input  logic [CHAR_W-1:0] tx_data,
    output logic              tx_ready,
    output logic              rx_valid,
    output logic [CHAR_W-1:0] rx_data,
    input  logic              rx_ready,
    input  logic              disc_req,
    output logic              link_up,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [MBX_W-1:0]  reg_wdata,
    output logic [MBX_W-1:0]  reg_rdata,
    output logic              remote_irq
);
    localparam logic [CW-1:0] DEPTH_C     = CW'(RX_DEPTH);
    localparam logic [CW-1:0] FULL_MARK_C = CW'(RX_DEPTH - HOLD_FREE);

    logic [MBX_W-1:0] rx_mbx, db_in, db_out, tx_mbx, status;
    logic [CW-1:0]    fifo_count;
    logic             hold, link, unknown_seen, tx_ring;
    logic             wr_rx, wr_tx, wr_dbin, wr_dbout;
    logic             push, hold_set, release_hold, clear_rx;
    logic [MBX_W-1:0] db_out_set, db_out_clr, db_in_set;
    db_event_e        ev;

    // Remote write strobes per register offset.
    always_comb begin
        wr_rx    = reg_we && (reg_addr == A_RXMBX);
        wr_tx    = reg_we && (reg_addr == A_TXMBX);
        wr_dbin  = reg_we && (reg_addr == A_DBIN);
        wr_dbout = reg_we && (reg_addr == A_DBOUT);
    end

    mbx_db_handler i_db_handler (
        .clk          (clk),
        .rst_n        (rst_n),
        .db_in        (db_in),
        .ev           (ev),
        .unknown_seen (unknown_seen)
    );

    mbx_tx_path #(
        .CHAR_W (CHAR_W)
    ) i_tx_path (
        .clk          (clk),
        .rst_n        (rst_n),
        .tx_valid     (tx_valid),
        .tx_data      (tx_data),
        .tx_ready     (tx_ready),
        .remote_wr    (wr_tx),
        .remote_wdata (reg_wdata),
        .mbx          (tx_mbx),
        .ring         (tx_ring)
    );

    // Receive-side decisions: store, hold and release.
    always_comb begin
        push         = (ev == EV_DATA) && (fifo_count != DEPTH_C);
        hold_set     = (ev == EV_DATA) && (fifo_count >= FULL_MARK_C);
        release_hold = hold && (fifo_count <= FULL_MARK_C);
        clear_rx     = (ev == EV_CONN)
                     || ((ev == EV_DATA) && !hold_set)
                     || (release_hold && !hold_set);
    end

    mbx_rx_fifo #(
        .DEPTH (RX_DEPTH),
        .W     (CHAR_W)
    ) i_rx_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (ev == EV_CONN),
        .push      (push),
        .push_data (rx_mbx[CHAR_W-1:0]),
        .out_valid (rx_valid),
        .out_data  (rx_data),
        .out_ready (rx_ready),
        .count     (fifo_count)
    );

    // Doorbell set and clear masks.
    always_comb begin
        db_out_set = '0;
        if (ev == EV_ALIVE) db_out_set = db_out_set | MSG_ALIVE;
        if (tx_ring)        db_out_set = db_out_set | MSG_DATA;
        if (disc_req)       db_out_set = db_out_set | MSG_DISC;
        db_out_clr = wr_dbout ? reg_wdata : '0;
        db_in_set  = wr_dbin ? reg_wdata : '0;
    end

    // Receive mailbox: remote writes win over local zeroing.
    always_ff @(posedge clk) begin
        if (!rst_n)        rx_mbx <= '0;
        else if (wr_rx)    rx_mbx <= reg_wdata;
        else if (clear_rx) rx_mbx <= '0;
    end

    // Doorbell words: local set wins over remote clear in the same cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            db_in  <= '0;
            db_out <= '0;
        end else begin
            db_in  <= ((ev != EV_NONE) ? '0 : db_in) | db_in_set;
            db_out <= (db_out & ~db_out_clr) | db_out_set;
        end
    end

    // Hold flag for receive flow control.
    always_ff @(posedge clk) begin
        if (!rst_n || ev == EV_CONN) hold <= 1'b0;
        else if (hold_set)           hold <= 1'b1;
        else if (release_hold)       hold <= 1'b0;
    end

    // Link state: a disconnect request wins over a connect in the same cycle.
    always_ff @(posedge clk) begin
        if (!rst_n || disc_req) link <= 1'b0;
        else if (ev == EV_CONN) link <= 1'b1;
    end

    // Status word and remote read mux.
    always_comb begin
        status              = '0;
        status[ST_UNKNOWN]  = unknown_seen;
        status[ST_LINK]     = link;
        status[ST_IN_PEND]  = (db_in != '0);
        status[ST_OUT_PEND] = (db_out != '0);
        unique case (reg_addr)
            A_RXMBX: reg_rdata = rx_mbx;
            A_TXMBX: reg_rdata = tx_mbx;
            A_DBIN:  reg_rdata = db_in;
            A_DBOUT: reg_rdata = db_out;
            A_STAT:  reg_rdata = status;
            default: reg_rdata = '0;
        endcase
        link_up    = link;
        remote_irq = (db_out != '0);
    end
endmodule

// File: rtl/mbx_con_checker.sv
// Temporal checks on the console endpoint. Bound to the top module.
module mbx_con_checker
    import mbx_con_pkg::*;
#(
    parameter int DEPTH     = 256,
    parameter int HOLD_FREE = 4,
    parameter int CW        = 9
) (
    input logic             clk,
    input logic             rst_n,
    input logic             tx_valid,
    input logic [7:0]       tx_data,
    input logic             tx_ready,
    input logic             disc_req,
    input logic             link,
    input logic             reg_we,
    input logic [2:0]       reg_addr,
    input logic [MBX_W-1:0] tx_mbx,
    input logic [MBX_W-1:0] rx_mbx,
    input logic [MBX_W-1:0] db_in,
    input logic [MBX_W-1:0] db_out,
    input logic             hold,
    input logic [CW-1:0]    count
);
    localparam logic [CW-1:0] DEPTH_C     = CW'(DEPTH);
    localparam logic [CW-1:0] FULL_MARK_C = CW'(DEPTH - HOLD_FREE);

    // R2: ready only while the transmit mailbox reads zero
    p_ready_needs_empty_r2: assert property (@(posedge clk) disable iff (!rst_n)
        tx_ready |-> (tx_mbx == '0));

    // R3: an accepted character lands marked in the mailbox
    p_tx_marked_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && tx_ready) |=> (tx_mbx == (TX_MARK | MBX_W'($past(tx_data)))));

    // R9: a pending incoming doorbell is cleared in the next cycle
    p_db_in_cleared_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ((db_in != '0) && !(reg_we && reg_addr == 3'd2)) |=> (db_in == '0));

    // R5: a ping is answered
    p_alive_reply_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (db_in == MSG_ALIVE) |=> db_out[0]);

    // R10: disconnect drops the link and rings the remote host
    p_disc_r10: assert property (@(posedge clk) disable iff (!rst_n)
        disc_req |=> (!link && db_out[1:0] == 2'b11));

    // R12: the fill level never exceeds the depth
    p_no_overflow_r12: assert property (@(posedge clk) disable iff (!rst_n)
        count <= DEPTH_C);

    // R8: a held mailbox keeps its value until room is made
    p_hold_keeps_mbx_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (hold && count > FULL_MARK_C && db_in != MSG_CONN && !(reg_we && reg_addr == 3'd0))
        |=> (rx_mbx == $past(rx_mbx)));
endmodule

bind mbx_console_endpoint mbx_con_checker #(
    .DEPTH     (RX_DEPTH),
    .HOLD_FREE (HOLD_FREE),
    .CW        (CW)
) i_mbx_con_checker (
    .clk      (clk),
    .rst_n    (rst_n),
    .tx_valid (tx_valid),
    .tx_data  (tx_data),
    .tx_ready (tx_ready),
    .disc_req (disc_req),
    .link     (link),
    .reg_we   (reg_we),
    .reg_addr (reg_addr),
    .tx_mbx   (tx_mbx),
    .rx_mbx   (rx_mbx),
    .db_in    (db_in),
    .db_out   (db_out),
    .hold     (hold),
    .count    (fifo_count)
);

// File: tb/test_mbx_console_endpoint.sv
module test_mbx_console_endpoint;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tx_valid = 1'b0;
    logic [7:0]  tx_data = '0;
    logic        tx_ready;
    logic        rx_valid;
    logic [7:0]  rx_data;
    logic        rx_ready = 1'b0;
    logic        disc_req = 1'b0;
    logic        link_up;
    logic        reg_we = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        remote_irq;

    int n_checks = 0;
    int n_fail   = 0;

    always #10 clk = ~clk;

    mbx_console_endpoint i_mbx_console_endpoint (
        .clk(clk), .rst_n(rst_n),
        .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready),
        .rx_valid(rx_valid), .rx_data(rx_data), .rx_ready(rx_ready),
        .disc_req(disc_req), .link_up(link_up),
        .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .remote_irq(remote_irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %08h expected %08h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic settle();
        @(negedge clk);
    endtask

    task automatic send(input logic [7:0] c);
        @(negedge clk);
        tx_valid = 1'b1; tx_data = c;
        #1;
        while (!tx_ready) @(negedge clk);
        @(negedge clk);
        tx_valid = 1'b0;
    endtask

    task automatic pop(output logic [7:0] d);
        #1;
        d = rx_data;
        rx_ready = 1'b1;
        @(negedge clk);
        rx_ready = 1'b0;
    endtask

    task automatic connect();
        wr(3'd2, 32'h2);
        settle();
    endtask

    task automatic t_reset();
        logic [31:0] v;
        for (int a = 0; a < 5; a++) begin
            rd(3'(a), v);
            chk("R1 register word zero", v, 32'h0);
        end
        chk("R1 tx_ready", 32'(tx_ready), 32'h1);
        chk("R1 rx_valid", 32'(rx_valid), 32'h0);
        chk("R1 link_up/remote_irq", {30'h0, link_up, remote_irq}, 32'h0);
    endtask

    task automatic t_alive();
        logic [31:0] v;
        wr(3'd2, 32'h1);
        rd(3'd4, v);
        chk("R9 inbound pending bit20", 32'(v[20]), 32'h1);
        settle();
        rd(3'd2, v);
        chk("R9 inbound doorbell cleared", v, 32'h0);
        rd(3'd3, v);
        chk("R5 ping answered", v, 32'h1);
        rd(3'd4, v);
        chk("R9 outbound pending bit21", 32'(v[21]), 32'h1);
        chk("R9 remote_irq high", 32'(remote_irq), 32'h1);
        wr(3'd3, 32'hFFFF_FFFF);
        rd(3'd3, v);
        chk("R9 outbound W1C", v, 32'h0);
        chk("R9 remote_irq low", 32'(remote_irq), 32'h0);
    endtask

    task automatic t_conn();
        logic [31:0] v;
        wr(3'd0, 32'h77);
        connect();
        rd(3'd0, v);
        chk("R6 receive mailbox zeroed", v, 32'h0);
        rd(3'd4, v);
        chk("R6 link bit", 32'(v[1]), 32'h1);
        chk("R6 link_up", 32'(link_up), 32'h1);
    endtask

    task automatic t_tx();
        logic [31:0] v;
        send(8'h41);
        rd(3'd1, v);
        chk("R2 marked character", v, 32'h8000_0041);
        rd(3'd3, v);
        chk("R2 data doorbell", v, 32'h5);
        chk("R2 tx_ready low while occupied", 32'(tx_ready), 32'h0);
        wr(3'd1, 32'h0);
        wr(3'd3, 32'hFFFF_FFFF);
        send(8'h00);
        rd(3'd1, v);
        chk("R3 NUL still nonzero", v, 32'h8000_0000);
        wr(3'd1, 32'h0);
        wr(3'd3, 32'hFFFF_FFFF);
    endtask

    task automatic t_newline();
        logic [31:0] v;
        send(8'h0A);
        rd(3'd1, v);
        chk("R4 newline sent", v, 32'h8000_000A);
        wr(3'd3, 32'hFFFF_FFFF);
        wr(3'd1, 32'h0);
        #1;
        chk("R4 tx_ready low before CR", 32'(tx_ready), 32'h0);
        settle();
        rd(3'd1, v);
        chk("R4 CR inserted", v, 32'h8000_000D);
        rd(3'd3, v);
        chk("R4 CR rings doorbell", v, 32'h5);
        wr(3'd1, 32'h0);
        wr(3'd3, 32'hFFFF_FFFF);
        #1;
        chk("R4 tx_ready after CR", 32'(tx_ready), 32'h1);
    endtask

    task automatic t_data();
        logic [31:0] v;
        logic [7:0]  b;
        logic [7:0]  exp_b [3] = '{8'h01, 8'hFF, 8'h80};
        connect();
        for (int i = 0; i < 3; i++) begin
            wr(3'd0, 32'hABCD_1200 | 32'(exp_b[i]));
            wr(3'd2, 32'h5);
            settle();
            rd(3'd0, v);
            chk("R7 mailbox zeroed after store", v, 32'h0);
        end
        for (int i = 0; i < 3; i++) begin
            chk("R7 rx_valid", 32'(rx_valid), 32'h1);
            pop(b);
            chk("R7 byte order", 32'(b), 32'(exp_b[i]));
        end
        chk("R7 buffer empty", 32'(rx_valid), 32'h0);
    endtask

    task automatic t_unknown();
        logic [31:0] v;
        wr(3'd0, 32'hAB);
        wr(3'd2, 32'h9);
        settle();
        rd(3'd4, v);
        chk("R11 sticky unknown bit", 32'(v[0]), 32'h1);
        rd(3'd0, v);
        chk("R11 mailbox untouched", v, 32'hAB);
        rd(3'd3, v);
        chk("R11 no reply", v, 32'h0);
        chk("R11 nothing stored", 32'(rx_valid), 32'h0);
        connect();
        rd(3'd4, v);
        chk("R11 bit stays set", 32'(v[0]), 32'h1);
    endtask

    task automatic t_hold();
        logic [31:0] v;
        logic [7:0]  exp_q [256];
        logic [7:0]  b;
        int          bad;
        connect();
        for (int i = 0; i < 253; i++) begin
            exp_q[i] = 8'(i) ^ 8'h5A;
            wr(3'd0, 32'h100 | 32'(exp_q[i]));
            wr(3'd2, 32'h5);
            settle();
            if (i == 251) begin
                rd(3'd0, v);
                chk("R8 mailbox zeroed at 4 free", v, 32'h0);
            end
        end
        rd(3'd0, v);
        chk("R8 mailbox held at 3 free", v, 32'h100 | 32'(exp_q[252]));
        for (int i = 0; i < 4; i++) begin
            wr(3'd2, 32'h5);
            settle();
        end
        for (int i = 253; i < 256; i++) exp_q[i] = exp_q[252];
        rd(3'd0, v);
        chk("R12 mailbox still held when full", v, 32'h100 | 32'(exp_q[252]));
        for (int i = 0; i < 3; i++) pop(b);
        rd(3'd0, v);
        chk("R8 held at 253 entries", v, 32'h100 | 32'(exp_q[252]));
        pop(b);
        settle();
        rd(3'd0, v);
        chk("R8 released at 252 entries", v, 32'h0);
        bad = 0;
        for (int i = 4; i < 256; i++) begin
            pop(b);
            if (b !== exp_q[i]) bad++;
        end
        chk("R12 drained order, extra store dropped", 32'(bad), 32'h0);
        chk("R12 buffer empty after 256", 32'(rx_valid), 32'h0);
    endtask

    task automatic t_disc();
        logic [31:0] v;
        @(negedge clk);
        disc_req = 1'b1;
        @(negedge clk);
        disc_req = 1'b0;
        rd(3'd3, v);
        chk("R10 disconnect doorbell", v, 32'h3);
        chk("R10 link dropped", 32'(link_up), 32'h0);
        wr(3'd3, 32'hFFFF_FFFF);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        settle();
        t_reset();
        t_alive();
        t_conn();
        t_tx();
        t_newline();
        t_data();
        t_unknown();
        t_hold();
        t_disc();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end
endmodule